// File: doc/BRIEF.md
# Inter-Packet Gap Stretch Calculator

This block decides how many bit times a transmitter must stay silent after each frame. When the transmit side finishes a frame, it offers the length of that frame in bits, with the preamble counted, on a valid/ready request channel. If stretching is switched on and the link runs full duplex, the gap is the offered length scaled by a programmable ratio. The low byte of a 16-bit configuration word is the multiplier. The high byte plus one is the divisor. The result never drops below the 96-bit standard minimum. In every other case the gap is simply 96 bit times.

The division runs iteratively, one quotient bit per clock. The finished gap is announced with a one-cycle `gap_valid` pulse. From that pulse on, a bit-time counter consumes `bit_tick` strobes and pulses `gap_elapsed` once the gap has run out. From acceptance until that pulse, the request channel shows not-ready. This stops a new frame from starting while the gap is still being computed or counted. The requester simply holds off: a request raised while `fe_ready` is low is not taken. The requester must raise it again once `fe_ready` returns high. The configuration and control pins are plain levels, sampled only in the accepting cycle.

Top module: `ipg_stretch_calc`

## Requirements
- R1: After reset `fe_ready` is 1, and `gap_busy`, `gap_valid` and `gap_elapsed` are 0.
- R2: With `stretch_en`=1 and `full_duplex`=1, the gap is floor(`fe_len` × `stretch_cfg[7:0]` ÷ (`stretch_cfg[15:8]` + 1)). The product is formed at its full 24-bit width before dividing, so 65535 × 255 ÷ 256 gives 65279.
- R3: A computed gap below 96 is raised to exactly 96. A multiplier of 0 therefore gives 96, and a length of 96 at ratio 1 gives 96.
- R4: With `stretch_en`=0 the gap is 96, whatever the length and configuration.
- R5: With `full_duplex`=0 the gap is 96. When no stretching applies, `gap_valid` rises in the cycle right after the accepting edge.
- R6: `gap_valid` is high for exactly one cycle, and `gap_bits` carries the gap in that cycle. `gap_bits` keeps that value until the next result.
- R7: A request is taken only when `fe_valid` and `fe_ready` are both high. `fe_ready` stays low from acceptance until `gap_elapsed` pulses. A request raised while `fe_ready` is low produces no result and no busy period.
- R8: `gap_elapsed` is a one-cycle pulse in the cycle after the clock edge that consumes the gap-th `bit_tick` after `gap_valid`. Ticks at or before the `gap_valid` edge are not counted.
- R9: `fe_len`, `stretch_cfg`, `stretch_en` and `full_duplex` are sampled only at acceptance. Changing them afterwards does not alter the result.
- R10: A divisor field of 0 divides by one, so no division by zero can occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_valid | input | 1 | Frame-end request valid |
| fe_ready | output | 1 | Frame-end request may be taken (no gap pending) |
| fe_len | input | 16 | Previous frame length in bits, preamble included |
| stretch_en | input | 1 | Stretching switched on |
| full_duplex | input | 1 | Link is full duplex |
| stretch_cfg | input | 16 | [7:0] multiplier, [15:8] divisor minus one |
| bit_tick | input | 1 | One strobe per bit time |
| gap_valid | output | 1 | One-cycle pulse: new gap on `gap_bits` |
| gap_bits | output | 24 | Gap length in bit times |
| gap_busy | output | 1 | Gap being computed or counted |
| gap_elapsed | output | 1 | One-cycle pulse: gap has run out |

## Verification
The bench builds the block with its default widths: a 16-bit length, an 8-bit multiplier and an 8-bit divisor field. This makes the 24-bit product and a 24-step division the exact limits the largest vector (65535 × 255 ÷ 256) presses against. These widths keep the longest gap near 65 thousand bit times. The bench can therefore count every tick of every gap to the final pulse, including the clamp boundary at 96 and 97. It keeps `bit_tick` running during the division, so that the ticks that must be ignored really do occur.

// File: rtl/ipg_pkg.sv
package ipg_pkg;
  localparam int MIN_GAP_BITS = 96;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIVIDE = 2'd1,
    ST_COUNT  = 2'd2
  } ipg_state_e;
endpackage

// File: rtl/ipg_mul.sv
module ipg_mul #(
  parameter int A_W = 16,
  parameter int B_W = 8
) (
  input  logic [A_W-1:0]     a,
  input  logic [B_W-1:0]     b,
  output logic [A_W+B_W-1:0] p
);
  localparam int P_W = A_W + B_W;
  // Both operands widened first so the product keeps every bit.
  assign p = P_W'(a) * P_W'(b);
endmodule

// File: rtl/ipg_div.sv
module ipg_div #(
  parameter int N_W = 24,
  parameter int D_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           done,
  output logic [N_W-1:0] quotient
);
  localparam int CNT_W = $clog2(N_W + 1);

  logic [D_W-1:0]   rem_q;
  logic [N_W-1:0]   quo_q;
  logic [D_W-1:0]   dvs_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic             done_q;
  logic [D_W:0]     shifted;
  logic             fits;

  assign shifted  = {rem_q, quo_q[N_W-1]};
  assign fits     = shifted >= {1'b0, dvs_q};
  assign done     = done_q;
  assign quotient = quo_q;

  // Restoring division, one quotient bit per clock, most significant first.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q    <= '0;
      quo_q    <= '0;
      dvs_q    <= D_W'(1);
      cnt_q    <= '0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
    end else if (start) begin
      rem_q    <= '0;
      quo_q    <= dividend;
      dvs_q    <= divisor;
      cnt_q    <= CNT_W'(N_W);
      active_q <= 1'b1;
      done_q   <= 1'b0;
    end else if (active_q) begin
      rem_q    <= fits ? D_W'(shifted - {1'b0, dvs_q}) : D_W'(shifted);
      quo_q    <= {quo_q[N_W-2:0], fits};
      cnt_q    <= cnt_q - CNT_W'(1);
      active_q <= cnt_q != CNT_W'(1);
      done_q   <= cnt_q == CNT_W'(1);
    end else begin
      done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ipg_gap_timer.sv
module ipg_gap_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         last,
  output logic         elapsed
);
  logic [W-1:0] left_q;
  logic         elapsed_q;

  assign last    = tick && (left_q == W'(1));
  assign elapsed = elapsed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q    <= '0;
      elapsed_q <= 1'b0;
    end else begin
      if (load) begin
        left_q <= load_val;
      end else if (tick && left_q != '0) begin
        left_q <= left_q - W'(1);
      end
      elapsed_q <= last;
    end
  end
endmodule

// File: rtl/ipg_stretch_calc.sv
module ipg_stretch_calc #(
  parameter int LEN_W = 16,
  parameter int MUL_W = 8,
  parameter int DIV_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fe_valid,
  output logic                   fe_ready,
  input  logic [LEN_W-1:0]       fe_len,
  input  logic                   stretch_en,
  input  logic                   full_duplex,
  input  logic [MUL_W+DIV_W-1:0] stretch_cfg,
  input  logic                   bit_tick,
  output logic                   gap_valid,
  output logic [LEN_W+MUL_W-1:0] gap_bits,
  output logic                   gap_busy,
  output logic                   gap_elapsed
);
  import ipg_pkg::*;

  localparam int GAP_W = LEN_W + MUL_W;
  localparam int DVS_W = DIV_W + 1;

  ipg_state_e       state_q;
  logic             accept;
  logic             stretch_on;
  logic [GAP_W-1:0] product;
  logic [DVS_W-1:0] divisor;
  logic             div_start;
  logic             div_done;
  logic [GAP_W-1:0] quotient;
  logic [GAP_W-1:0] clamped;
  logic             timer_load;
  logic [GAP_W-1:0] load_val;
  logic             timer_last;
  logic [GAP_W-1:0] gap_q;
  logic             gap_valid_q;

  assign fe_ready   = state_q == ST_IDLE;
  assign accept     = fe_valid && fe_ready;
  assign stretch_on = stretch_en && full_duplex;
  assign divisor    = DVS_W'(stretch_cfg[MUL_W+DIV_W-1:MUL_W]) + DVS_W'(1);
  assign div_start  = accept && stretch_on;

  ipg_mul #(.A_W(LEN_W), .B_W(MUL_W)) mul_i (
    .a (fe_len),
    .b (stretch_cfg[MUL_W-1:0]),
    .p (product)
  );

  ipg_div #(.N_W(GAP_W), .D_W(DVS_W)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (product),
    .divisor  (divisor),
    .done     (div_done),
    .quotient (quotient)
  );

  assign clamped    = (quotient < GAP_W'(MIN_GAP_BITS)) ? GAP_W'(MIN_GAP_BITS) : quotient;
  assign timer_load = (accept && !stretch_on) || (state_q == ST_DIVIDE && div_done);
  assign load_val   = (state_q == ST_DIVIDE) ? clamped : GAP_W'(MIN_GAP_BITS);

  ipg_gap_timer #(.W(GAP_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (load_val),
    .tick     (bit_tick && state_q == ST_COUNT),
    .last     (timer_last),
    .elapsed  (gap_elapsed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      gap_q       <= GAP_W'(MIN_GAP_BITS);
      gap_valid_q <= 1'b0;
    end else begin
      gap_valid_q <= timer_load;
      if (timer_load) gap_q <= load_val;
      unique case (state_q)
        ST_IDLE:   if (accept) state_q <= stretch_on ? ST_DIVIDE : ST_COUNT;
        ST_DIVIDE: if (div_done) state_q <= ST_COUNT;
        ST_COUNT:  if (timer_last) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign gap_valid = gap_valid_q;
  assign gap_bits  = gap_q;
  assign gap_busy  = state_q != ST_IDLE;
endmodule

// File: rtl/ipg_stretch_chk.sv
module ipg_stretch_chk #(
  parameter int GAP_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fe_valid,
  input logic             fe_ready,
  input logic             stretch_en,
  input logic             full_duplex,
  input logic             gap_valid,
  input logic [GAP_W-1:0] gap_bits,
  input logic             gap_busy,
  input logic             gap_elapsed
);
  assert_take_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && fe_ready) |=> (gap_busy && !fe_ready));

  assert_floor_96_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_valid |-> (gap_bits >= GAP_W'(96)));

  assert_plain_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && fe_ready && !stretch_en) |=> (gap_valid && gap_bits == GAP_W'(96)));

  assert_half_duplex_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_valid && fe_ready && !full_duplex) |=> (gap_valid && gap_bits == GAP_W'(96)));

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_valid |=> !gap_valid);

  assert_hold_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !gap_valid |-> $stable(gap_bits));

  assert_elapsed_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_elapsed |-> (!gap_busy && $past(gap_busy)));
endmodule

bind ipg_stretch_calc ipg_stretch_chk #(.GAP_W(LEN_W + MUL_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fe_valid    (fe_valid),
  .fe_ready    (fe_ready),
  .stretch_en  (stretch_en),
  .full_duplex (full_duplex),
  .gap_valid   (gap_valid),
  .gap_bits    (gap_bits),
  .gap_busy    (gap_busy),
  .gap_elapsed (gap_elapsed)
);

// File: tb/ipg_stretch_calc_tb.sv
module ipg_stretch_calc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fe_valid = 1'b0;
  logic        fe_ready;
  logic [15:0] fe_len = '0;
  logic        stretch_en = 1'b0;
  logic        full_duplex = 1'b0;
  logic [15:0] stretch_cfg = '0;
  logic        bit_tick = 1'b0;
  logic        gap_valid;
  logic [23:0] gap_bits;
  logic        gap_busy;
  logic        gap_elapsed;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  ipg_stretch_calc dut_i (
    .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_ready(fe_ready),
    .fe_len(fe_len), .stretch_en(stretch_en), .full_duplex(full_duplex),
    .stretch_cfg(stretch_cfg), .bit_tick(bit_tick), .gap_valid(gap_valid),
    .gap_bits(gap_bits), .gap_busy(gap_busy), .gap_elapsed(gap_elapsed)
  );

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] cfg;
    logic        en;
    logic        fd;
    logic [23:0] exp_gap;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{16'd512,   16'h0001, 1'b1, 1'b1, 24'd512},    // R2 ratio 1, R10
    '{16'd512,   16'h0103, 1'b1, 1'b1, 24'd768},    // R2 3/2
    '{16'd1000,  16'h0207, 1'b1, 1'b1, 24'd2333},   // R2 truncation 7000/3
    '{16'd80,    16'h0001, 1'b1, 1'b1, 24'd96},     // R3 clamp
    '{16'd5000,  16'h0000, 1'b1, 1'b1, 24'd96},     // R3 zero multiplier
    '{16'd5000,  16'h0103, 1'b0, 1'b1, 24'd96},     // R4
    '{16'd5000,  16'h0103, 1'b1, 1'b0, 24'd96},     // R5
    '{16'd65535, 16'hFFFF, 1'b1, 1'b1, 24'd65279},  // R2 full width
    '{16'd96,    16'h0001, 1'b1, 1'b1, 24'd96},     // R3 boundary
    '{16'd97,    16'h0001, 1'b1, 1'b1, 24'd97},     // R3 just above
    '{16'd3000,  16'h0500, 1'b0, 1'b0, 24'd96}      // R4 R5 both off
  };

  task automatic check(input logic ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Offer one request, scramble the inputs (R9), then follow it to the end.
  task automatic run_one(input vec_t v, input string req);
    int waited;
    int ticks;
    logic plain;
    plain = !(v.en && v.fd);
    @(negedge clk);
    check(fe_ready == 1'b1, "R7 ready before request", fe_ready, 1);
    fe_valid = 1'b1;
    fe_len = v.len;
    stretch_cfg = v.cfg;
    stretch_en = v.en;
    full_duplex = v.fd;
    @(posedge clk);
    @(negedge clk);
    fe_valid = 1'b0;
    fe_len = 16'hFFFF;          // R9 later changes have no effect
    stretch_cfg = 16'h00FF;
    stretch_en = ~v.en;
    full_duplex = ~v.fd;
    bit_tick = 1'b1;            // R8 ticks before gap_valid must be ignored
    check(fe_ready == 1'b0, "R7 not ready after take", fe_ready, 0);
    if (plain) check(gap_valid == 1'b1, "R5 valid next cycle", gap_valid, 1);
    waited = 0;
    while (!gap_valid && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check(gap_bits == v.exp_gap, req, gap_bits, v.exp_gap);
    ticks = 0;
    while (!gap_elapsed && ticks < 70000) begin
      @(posedge clk);
      ticks++;
      @(negedge clk);
      if (gap_valid) check(1'b0, "R6 valid wider than one cycle", 1, 0);
    end
    check(ticks == int'(v.exp_gap), "R8 tick count to elapsed", ticks, v.exp_gap);
    check(fe_ready && !gap_busy, "R7 ready after elapsed", fe_ready, 1);
    bit_tick = 1'b0;
    @(negedge clk);
    check(gap_elapsed == 1'b0, "R8 elapsed one cycle", gap_elapsed, 0);
    check(gap_bits == v.exp_gap, "R6 gap_bits held", gap_bits, v.exp_gap);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(fe_ready == 1'b1, "R1 reset fe_ready", fe_ready, 1);
    check(!gap_busy && !gap_valid && !gap_elapsed, "R1 reset outputs",
          {gap_busy, gap_valid, gap_elapsed}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_one(VECS[i], "R2 R3 R4 R5 R9 R10 gap value");
    end

    // R7: a request raised while not ready is dropped.
    @(negedge clk);
    fe_valid = 1'b1; fe_len = 16'd200; stretch_cfg = 16'h0001;
    stretch_en = 1'b0; full_duplex = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fe_valid = 1'b1; fe_len = 16'd40000; stretch_cfg = 16'h0003;
    stretch_en = 1'b1;
    check(fe_ready == 1'b0, "R7 ready low while counting", fe_ready, 0);
    @(posedge clk);
    @(negedge clk);
    fe_valid = 1'b0;
    bit_tick = 1'b1;
    for (int k = 0; k < 200 && !gap_elapsed; k++) @(negedge clk);
    bit_tick = 1'b0;
    check(gap_bits == 24'd96, "R7 first result kept", gap_bits, 96);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (gap_valid || gap_busy) check(1'b0, "R7 dropped request produced work", 1, 0);
    end
    check(!gap_busy && fe_ready, "R7 idle after dropped request", gap_busy, 0);

    // R1: reset in the middle of a divide clears everything.
    fe_valid = 1'b1; fe_len = 16'd9000; stretch_cfg = 16'h0002;
    stretch_en = 1'b1; full_duplex = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fe_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!gap_busy && fe_ready && gap_bits == 24'd96, "R1 reset mid divide", gap_bits, 96);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(!gap_valid && !gap_busy, "R1 no result after reset", gap_valid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule